// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is the control engine of one DMA channel. Software programs a source pointer, a destination pointer, a transfer count and a control word through a small register-write port, then sets the channel enable. From then on the engine runs one bus transfer unit for each request. A request comes from an internal auto-request, or from an external request line that is sensed by level or by edge. After each unit both pointers move by the configured step and the count drops by one.

The engine raises a half-way flag and an end flag, each with its own optional interrupt. It can refill the working pointers and count from shadow registers when a run completes. It stops between units whenever the channel or master enable is cleared, or when an NMI, address-error or end flag is set. Data movement, channel arbitration and width conversion belong to the bus side. The engine only presents addresses and a unit size, and waits for a done strobe.

Top module: `dma_chan_seq`

Register select (`wr_sel`): 0 source, 1 destination, 2 count, 3 control, 4 shadow source, 5 shadow destination, 6 shadow count, 7 global. Control word bits: 0 channel enable, 1 end-flag keep, 2 end interrupt enable, 3 half interrupt enable, 4 half-flag keep, 6:5 source mode, 8:7 destination mode, 10:9 unit size, 11 auto request, 12 burst, 13 edge sense, 14 reload enable, 15 acknowledge to requester. Global word bits: 0 master enable, 1 NMI-flag keep, 2 address-error-flag keep.

## Requirements
- R1: A unit starts only when channel enable and master enable are 1, the NMI, address-error and end flags are 0, and the count is nonzero. A count of 0 starts nothing.
- R2: With auto request (control bit 11 = 1) units start with no external request, one after another until the count is exhausted.
- R3: Each request produces exactly one bus transfer. `bus_req` stays high until `bus_done`, and the count then drops by 1.
- R4: Each pointer moves per its mode after a unit: 0 fixed, 1 increment, 2 decrement, 3 fixed. The step is the unit size: size code 0 is 1 byte, 1 is 2 bytes, 2 and 3 are 4 bytes.
- R5: When the count reaches 0 the end flag sets. `irq_end` is high while the end flag and the end interrupt enable are both 1.
- R6: The half flag sets after the unit that leaves the count equal to floor(initial count / 2). `irq_half` is high while the half flag and the half interrupt enable are both 1.
- R7: With reload enabled, completion copies the shadow source, destination and count into the working registers. The shadow count also becomes the new initial count.
- R8: Clearing channel or master enable, or an `nmi_evt` pulse (which sets the NMI flag), stops the channel after the unit in flight. Clearing the cause lets the run resume.
- R9: With control bit 15 = 1, `dack` pulses for one cycle with each `bus_done`. With bit 15 = 0 it stays low.
- R10: The external request is level-sensed in cycle-steal mode and in burst mode with bit 13 = 0. It is edge-sensed in burst mode with bit 13 = 1. One rising edge gives one unit, and an edge that arrives during a transfer is held until its unit starts.
- R11: In cycle-steal mode (bit 12 = 0) `bus_lock` drops after every unit. In burst mode it stays high between units until the run ends or stops.
- R12: If either pointer is not aligned to the unit size when a unit would start, the address-error flag sets and no transfer is issued.
- R13: Writing 0 to a keep bit clears that flag, and writing 1 leaves it unchanged. A hardware set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select |
| wr_data | input | 32 | Write data |
| nmi_evt | input | 1 | Pulse that sets the NMI flag |
| dreq | input | 1 | External transfer request |
| bus_req | output | 1 | Transfer unit requested on the bus |
| bus_lock | output | 1 | Bus held by this channel |
| bus_src | output | 32 | Source address of the current unit |
| bus_dst | output | 32 | Destination address of the current unit |
| bus_size | output | 2 | Unit size code |
| bus_done | input | 1 | Bus side finished the current unit |
| dack | output | 1 | Acknowledge pulse to the requester |
| irq_end | output | 1 | End interrupt |
| irq_half | output | 1 | Half-way interrupt |
| cur_src | output | 32 | Working source pointer |
| cur_dst | output | 32 | Working destination pointer |
| cur_cnt | output | 16 | Remaining count |
| tend_flag | output | 1 | End flag |
| half_flag | output | 1 | Half flag |
| nmi_flag | output | 1 | NMI flag |
| addr_err_flag | output | 1 | Address-error flag |

## Verification
On every cycle the assertions check several things: the start gate, that the request is held until the done strobe, the count step and the end flag, the copy on reload, fixed-pointer stability, flag stickiness, acknowledge timing, bus release in cycle-steal mode, and that a misaligned unit issues nothing. Other behaviour needs whole runs, so only the bench scenarios show it. That covers the exact address sequence for every mode and size mix, the cycle at which the half flag appears for each initial count, resuming after a stop, and how edge and level requests map to unit counts.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;

  typedef enum logic [1:0] {
    AM_FIX = 2'd0,
    AM_INC = 2'd1,
    AM_DEC = 2'd2,
    AM_RSV = 2'd3
  } amode_t;

  typedef struct packed {
    logic   chan_en;
    logic   end_ie;
    logic   half_ie;
    amode_t smode;
    amode_t dmode;
    logic [1:0] usize;
    logic   auto_req;
    logic   burst;
    logic   edge_sel;
    logic   reload;
    logic   per_ack;
  } chctl_t;

  // bytes moved by one unit for a size code
  function automatic logic [3:0] unit_bytes(logic [1:0] sz);
    case (sz)
      2'd0:    return 4'd1;
      2'd1:    return 4'd2;
      default: return 4'd4;
    endcase
  endfunction

  // signed pointer step for a mode and size
  function automatic logic signed [3:0] addr_step(amode_t m, logic [1:0] sz);
    logic [3:0] b;
    b = unit_bytes(sz);
    case (m)
      AM_INC:  return b;
      AM_DEC:  return -b;
      default: return 4'sd0;
    endcase
  endfunction

  // low address bits agree with the unit size
  function automatic logic lo_aligned(logic [1:0] lo, logic [1:0] sz);
    case (sz)
      2'd0:    return 1'b1;
      2'd1:    return ~lo[0];
      default: return (lo == 2'b00);
    endcase
  endfunction

  function automatic chctl_t ctl_decode(logic [15:0] w);
    chctl_t c;
    c.chan_en  = w[0];
    c.end_ie   = w[2];
    c.half_ie  = w[3];
    c.smode    = amode_t'(w[6:5]);
    c.dmode    = amode_t'(w[8:7]);
    c.usize    = w[10:9];
    c.auto_req = w[11];
    c.burst    = w[12];
    c.edge_sel = w[13];
    c.reload   = w[14];
    c.per_ack  = w[15];
    return c;
  endfunction

endpackage

// File: rtl/dmaseq_regs.sv
module dmaseq_regs
  import dmaseq_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          nmi_evt,
  input  logic          unit_done,
  input  logic          ae_set,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic [CW-1:0] cnt,
  output chctl_t        ctl,
  output logic          master_en,
  output logic          tend,
  output logic          half,
  output logic          nmi_f,
  output logic          ae_f,
  output logic          reload_fire
);

  localparam logic [2:0] SEL_SRC  = 3'd0;
  localparam logic [2:0] SEL_DST  = 3'd1;
  localparam logic [2:0] SEL_CNT  = 3'd2;
  localparam logic [2:0] SEL_CTL  = 3'd3;
  localparam logic [2:0] SEL_RSRC = 3'd4;
  localparam logic [2:0] SEL_RDST = 3'd5;
  localparam logic [2:0] SEL_RCNT = 3'd6;
  localparam logic [2:0] SEL_GLB  = 3'd7;
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic [AW-1:0] rsrc, rdst;
  logic [CW-1:0] rcnt, init_cnt;
  logic [CW-1:0] cnt_next;
  logic          end_hit, half_hit;
  logic signed [3:0] sstep, dstep;

  assign cnt_next    = cnt - CNT_ONE;
  assign end_hit     = unit_done && (cnt_next == '0);
  assign half_hit    = unit_done && (cnt_next == (init_cnt >> 1));
  assign reload_fire = end_hit && ctl.reload;
  assign sstep       = addr_step(ctl.smode, ctl.usize);
  assign dstep       = addr_step(ctl.dmode, ctl.usize);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src <= '0; dst <= '0; cnt <= '0; init_cnt <= '0;
      rsrc <= '0; rdst <= '0; rcnt <= '0;
      ctl <= '0; master_en <= 1'b0;
      tend <= 1'b0; half <= 1'b0; nmi_f <= 1'b0; ae_f <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_sel)
          SEL_SRC:  src  <= wr_data[AW-1:0];
          SEL_DST:  dst  <= wr_data[AW-1:0];
          SEL_CNT: begin
            cnt      <= wr_data[CW-1:0];
            init_cnt <= wr_data[CW-1:0];
          end
          SEL_CTL: begin
            ctl  <= ctl_decode(wr_data[15:0]);
            tend <= tend & wr_data[1];
            half <= half & wr_data[4];
          end
          SEL_RSRC: rsrc <= wr_data[AW-1:0];
          SEL_RDST: rdst <= wr_data[AW-1:0];
          SEL_RCNT: rcnt <= wr_data[CW-1:0];
          SEL_GLB: begin
            master_en <= wr_data[0];
            nmi_f     <= nmi_f & wr_data[1];
            ae_f      <= ae_f & wr_data[2];
          end
          default: ;
        endcase
      end
      // hardware updates take precedence over software writes
      if (unit_done) begin
        src <= src + {{(AW-4){sstep[3]}}, sstep};
        dst <= dst + {{(AW-4){dstep[3]}}, dstep};
        cnt <= cnt_next;
      end
      if (reload_fire) begin
        src      <= rsrc;
        dst      <= rdst;
        cnt      <= rcnt;
        init_cnt <= rcnt;
      end
      if (end_hit)  tend  <= 1'b1;
      if (half_hit) half  <= 1'b1;
      if (nmi_evt)  nmi_f <= 1'b1;
      if (ae_set)   ae_f  <= 1'b1;
    end
  end

  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && !reload_fire) |=> (cnt == $past(cnt) - CNT_ONE));

  a_r5_end_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && cnt == CNT_ONE) |=> tend);

  a_r7_reload_copy: assert property (@(posedge clk) disable iff (!rst_n)
    reload_fire |=> (src == $past(rsrc) && dst == $past(rdst) && cnt == $past(rcnt)));

  a_r4_fixed_src: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && !reload_fire && (ctl.smode == AM_FIX || ctl.smode == AM_RSV)
     && !(wr_en && wr_sel == SEL_SRC)) |=> (src == $past(src)));

  a_r13_tend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tend && !(wr_en && wr_sel == SEL_CTL && !wr_data[1])) |=> tend);

endmodule

// File: rtl/dmaseq_reqdet.sv
module dmaseq_reqdet (
  input  logic clk,
  input  logic rst_n,
  input  logic dreq,
  input  logic auto_req,
  input  logic burst,
  input  logic edge_sel,
  input  logic taken,
  output logic req
);

  logic dreq_q, pend, rise, edge_mode;

  assign rise      = dreq && !dreq_q;
  assign edge_mode = burst && edge_sel && !auto_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dreq_q <= 1'b0;
      pend   <= 1'b0;
    end else begin
      dreq_q <= dreq;
      pend   <= rise || (pend && !taken);
    end
  end

  always_comb begin
    if (auto_req)       req = 1'b1;
    else if (edge_mode) req = pend;
    else                req = dreq;
  end

  a_r10_edge_held: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !taken) |=> pend);

  a_r10_rise_caught: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> pend);

endmodule

// File: rtl/dmaseq_fsm.sv
module dmaseq_fsm
  import dmaseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chan_en,
  input  logic       master_en,
  input  logic       nmi_f,
  input  logic       ae_f,
  input  logic       tend,
  input  logic       cnt_nz,
  input  logic       cnt_last,
  input  logic       req,
  input  logic [1:0] src_lo,
  input  logic [1:0] dst_lo,
  input  logic [1:0] usize,
  input  logic       burst,
  input  logic       per_ack,
  input  logic       bus_done,
  output logic       bus_req,
  output logic       bus_lock,
  output logic       unit_start,
  output logic       unit_done,
  output logic       ae_set,
  output logic       dack
);

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} st_t;

  st_t  st;
  logic held;
  logic run_ok, misal;

  assign run_ok     = chan_en && master_en && !nmi_f && !ae_f && !tend && cnt_nz;
  assign misal      = !lo_aligned(src_lo, usize) || !lo_aligned(dst_lo, usize);
  assign unit_start = (st == ST_IDLE) && run_ok && req && !misal;
  assign ae_set     = (st == ST_IDLE) && run_ok && req && misal;
  assign unit_done  = (st == ST_RUN) && bus_done;
  assign bus_req    = (st == ST_RUN);
  assign bus_lock   = (st == ST_RUN) || held;
  assign dack       = unit_done && per_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      held <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          held <= 1'b0;
          if (unit_start) st <= ST_RUN;
        end
        ST_RUN: begin
          if (bus_done) begin
            st   <= ST_IDLE;
            held <= burst && !cnt_last;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  a_r1_start_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(chan_en && master_en && !nmi_f && !ae_f && !tend && cnt_nz));

  a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_done) |=> bus_req);

  a_r9_dack_timing: assert property (@(posedge clk) disable iff (!rst_n)
    dack |-> (bus_req && bus_done && per_ack));

  a_r11_steal_release: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && !burst) |=> !bus_lock);

  a_r12_no_misaligned_unit: assert property (@(posedge clk) disable iff (!rst_n)
    ae_set |=> !bus_req);

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dmaseq_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          nmi_evt,
  input  logic          dreq,
  output logic          bus_req,
  output logic          bus_lock,
  output logic [AW-1:0] bus_src,
  output logic [AW-1:0] bus_dst,
  output logic [1:0]    bus_size,
  input  logic          bus_done,
  output logic          dack,
  output logic          irq_end,
  output logic          irq_half,
  output logic [AW-1:0] cur_src,
  output logic [AW-1:0] cur_dst,
  output logic [CW-1:0] cur_cnt,
  output logic          tend_flag,
  output logic          half_flag,
  output logic          nmi_flag,
  output logic          addr_err_flag
);

  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  chctl_t        ctl;
  logic [AW-1:0] src, dst;
  logic [CW-1:0] cnt;
  logic          master_en, tend, half, nmi_f, ae_f, reload_fire;
  logic          unit_start, unit_done, ae_set, req;

  dmaseq_regs #(.AW(AW), .CW(CW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .nmi_evt(nmi_evt), .unit_done(unit_done), .ae_set(ae_set),
    .src(src), .dst(dst), .cnt(cnt), .ctl(ctl),
    .master_en(master_en), .tend(tend), .half(half),
    .nmi_f(nmi_f), .ae_f(ae_f), .reload_fire(reload_fire)
  );

  dmaseq_reqdet u_req (
    .clk(clk), .rst_n(rst_n), .dreq(dreq),
    .auto_req(ctl.auto_req), .burst(ctl.burst), .edge_sel(ctl.edge_sel),
    .taken(unit_start), .req(req)
  );

  dmaseq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .chan_en(ctl.chan_en), .master_en(master_en),
    .nmi_f(nmi_f), .ae_f(ae_f), .tend(tend),
    .cnt_nz(cnt != '0), .cnt_last(cnt == CNT_ONE), .req(req),
    .src_lo(src[1:0]), .dst_lo(dst[1:0]), .usize(ctl.usize),
    .burst(ctl.burst), .per_ack(ctl.per_ack), .bus_done(bus_done),
    .bus_req(bus_req), .bus_lock(bus_lock),
    .unit_start(unit_start), .unit_done(unit_done),
    .ae_set(ae_set), .dack(dack)
  );

  assign bus_src       = src;
  assign bus_dst       = dst;
  assign bus_size      = ctl.usize;
  assign irq_end       = tend && ctl.end_ie;
  assign irq_half      = half && ctl.half_ie;
  assign cur_src       = src;
  assign cur_dst       = dst;
  assign cur_cnt       = cnt;
  assign tend_flag     = tend;
  assign half_flag     = half;
  assign nmi_flag      = nmi_f;
  assign addr_err_flag = ae_f;

  a_r8_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_req && (nmi_f || !master_en || !ctl.chan_en)) |=> !bus_req);

  a_r5_reload_keeps_end: assert property (@(posedge clk) disable iff (!rst_n)
    reload_fire |=> tend);

endmodule

// File: tb/sim_dma_chan_seq.sv
module sim_dma_chan_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        nmi_evt = 1'b0;
  logic        dreq = 1'b0;
  logic        bus_done = 1'b0;
  logic        bus_req, bus_lock, dack, irq_end, irq_half;
  logic [31:0] bus_src, bus_dst, cur_src, cur_dst;
  logic [1:0]  bus_size;
  logic [15:0] cur_cnt;
  logic        tend_flag, half_flag, nmi_flag, addr_err_flag;

  int n_tests = 0;
  int n_fail  = 0;
  int lat = 1;
  int nunits = 0, ndack = 0, gaps = 0;
  int half_at = -1;
  bit half_seen = 0;
  logic [31:0] log_src [64];
  logic [31:0] log_dst [64];

  always #2.5 clk = ~clk;

  dma_chan_seq u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .nmi_evt(nmi_evt), .dreq(dreq), .bus_req(bus_req), .bus_lock(bus_lock),
    .bus_src(bus_src), .bus_dst(bus_dst), .bus_size(bus_size), .bus_done(bus_done),
    .dack(dack), .irq_end(irq_end), .irq_half(irq_half),
    .cur_src(cur_src), .cur_dst(cur_dst), .cur_cnt(cur_cnt),
    .tend_flag(tend_flag), .half_flag(half_flag), .nmi_flag(nmi_flag),
    .addr_err_flag(addr_err_flag)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bus responder: raise done after lat waiting cycles, log each unit
  initial begin
    int w;
    w = 0;
    forever begin
      @(negedge clk);
      if (bus_done) bus_done = 1'b0;
      else if (bus_req) begin
        if (w >= lat) begin
          bus_done = 1'b1;
          w = 0;
          if (nunits < 64) begin
            log_src[nunits] = bus_src;
            log_dst[nunits] = bus_dst;
          end
          nunits++;
          #1;
          if (dack) ndack++;
        end else w++;
      end else w = 0;
    end
  end

  // lock gaps and half-point monitor
  initial begin
    forever begin
      @(negedge clk);
      #0.5;
      if (rst_n && nunits > 0 && !tend_flag && !bus_lock) gaps++;
      if (rst_n && half_flag && !half_seen) begin
        half_seen = 1;
        half_at = int'(cur_cnt);
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic do_reset();
    rst_n = 1'b0;
    dreq = 1'b0;
    nmi_evt = 1'b0;
    lat = 1;
    repeat (3) @(negedge clk);
    nunits = 0; ndack = 0; gaps = 0; half_seen = 0; half_at = -1;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] cw(bit en, bit keep, bit eie, bit hie, logic [1:0] sm,
                                     logic [1:0] dm, logic [1:0] sz, bit au, bit bu,
                                     bit ed, bit rl, bit pe);
    return {16'h0, pe, rl, ed, bu, au, sz, dm, sm, keep, hie, eie, keep, en};
  endfunction

  task automatic wait_end(input int maxc);
    for (int i = 0; i < maxc && !tend_flag; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_addr(logic [31:0] base, logic [1:0] m, logic [1:0] sz, int k);
    int b;
    b = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    if (m == 1) return base + 32'(k * b);
    if (m == 2) return base - 32'(k * b);
    return base;
  endfunction

  initial begin
    logic [31:0] u;
    do_reset();
    // reset state
    chk(cur_cnt == 0 && !tend_flag && !half_flag, "R1 reset regs", {16'h0, cur_cnt}, 0);
    chk(!bus_req && !bus_lock && !irq_end && !irq_half, "R1 reset outputs", {28'h0, bus_req, bus_lock, irq_end, irq_half}, 0);
    // writing 1 to keep bit with flag clear has no effect
    wr(3, cw(0, 1, 1, 1, 0, 0, 0, 1, 0, 0, 0, 0));
    repeat (3) @(negedge clk);
    chk(!tend_flag && !half_flag, "R13 keep-1 no set", {30'h0, tend_flag, half_flag}, 0);
    // count 0 starts nothing
    wr(7, 32'h1);
    wr(3, cw(1, 1, 1, 0, 1, 1, 0, 1, 0, 0, 0, 0));
    repeat (20) @(negedge clk);
    chk(nunits == 0 && !tend_flag, "R1 zero count idle", nunits, 0);

    // sweep all mode and size combinations, auto cycle-steal
    for (int sz = 0; sz < 3; sz++)
      for (int sm = 0; sm < 3; sm++)
        for (int dm = 0; dm < 3; dm++) begin
          bit pe, eie;
          pe  = sm[0];
          eie = (sz != 1);
          do_reset();
          wr(7, 32'h1);
          wr(0, 32'h1000); wr(1, 32'h2000); wr(2, 32'd5);
          wr(3, cw(1, 1, eie, 1, 2'(sm), 2'(dm), 2'(sz), 1, 0, 0, 0, pe));
          wait_end(200);
          chk(nunits == 5, "R2 R3 unit count", nunits, 5);
          for (int k = 0; k < 5; k++) begin
            chk(log_src[k] == exp_addr(32'h1000, 2'(sm), 2'(sz), k), "R4 src seq", log_src[k], exp_addr(32'h1000, 2'(sm), 2'(sz), k));
            chk(log_dst[k] == exp_addr(32'h2000, 2'(dm), 2'(sz), k), "R4 dst seq", log_dst[k], exp_addr(32'h2000, 2'(dm), 2'(sz), k));
          end
          chk(cur_src == exp_addr(32'h1000, 2'(sm), 2'(sz), 5), "R4 final src", cur_src, exp_addr(32'h1000, 2'(sm), 2'(sz), 5));
          chk(cur_cnt == 0 && tend_flag, "R5 end flag", {15'h0, tend_flag, cur_cnt}, 32'h10000);
          chk(irq_end == eie, "R5 irq_end gating", irq_end, eie);
          chk(ndack == (pe ? 5 : 0), "R9 dack count", ndack, pe ? 5 : 0);
          chk(gaps > 0, "R11 steal releases", gaps, 1);
        end

    // half point for initial counts 1..8
    for (int n = 1; n <= 8; n++) begin
      do_reset();
      wr(7, 32'h1);
      wr(0, 32'h100); wr(1, 32'h200); wr(2, 32'(n));
      wr(3, cw(1, 1, 0, 1, 1, 1, 0, 1, 0, 0, 0, 0));
      wait_end(200);
      chk(half_at == (n >> 1), "R6 half point", half_at, n >> 1);
      chk(irq_half && half_flag, "R6 irq_half", irq_half, 1);
    end
    // half flag clear by writing 0, stays clear
    wr(3, cw(0, 0, 0, 1, 1, 1, 0, 1, 0, 0, 0, 0));
    repeat (2) @(negedge clk);
    chk(!half_flag && !tend_flag && !irq_half, "R13 clear by 0", {30'h0, half_flag, tend_flag}, 0);

    // burst auto holds bus
    do_reset();
    lat = 2;
    wr(7, 32'h1);
    wr(0, 32'h40); wr(1, 32'h80); wr(2, 32'd6);
    wr(3, cw(1, 1, 0, 0, 1, 1, 2, 1, 1, 0, 0, 0));
    wait_end(300);
    chk(nunits == 6, "R2 burst units", nunits, 6);
    chk(gaps == 0, "R11 burst holds", gaps, 0);
    chk(!bus_lock, "R11 burst release at end", bus_lock, 0);

    // reload
    do_reset();
    wr(7, 32'h1);
    wr(0, 32'h1000); wr(1, 32'h2000); wr(2, 32'd2);
    wr(4, 32'h3000); wr(5, 32'h4000); wr(6, 32'd3);
    wr(3, cw(1, 1, 1, 0, 1, 1, 0, 1, 0, 0, 1, 0));
    wait_end(200);
    chk(nunits == 2 && tend_flag, "R7 first run", nunits, 2);
    chk(cur_src == 32'h3000 && cur_dst == 32'h4000, "R7 reload ptrs", cur_src, 32'h3000);
    chk(cur_cnt == 3, "R7 reload count", cur_cnt, 3);
    wr(3, cw(1, 1, 1, 0, 1, 1, 0, 1, 0, 0, 1, 0));
    repeat (10) @(negedge clk);
    chk(nunits == 2, "R13 keep-1 end stays", nunits, 2);
    wr(3, cw(1, 0, 1, 0, 1, 1, 0, 1, 0, 0, 1, 0));
    wait_end(200);
    chk(nunits == 5 && log_src[2] == 32'h3000 && log_dst[4] == 32'h4002, "R7 second run", log_dst[4], 32'h4002);

    // termination by master disable, then NMI
    do_reset();
    lat = 2;
    dreq = 1'b1;
    wr(7, 32'h1);
    wr(0, 32'h0); wr(1, 32'h10); wr(2, 32'd10);
    wr(3, cw(1, 1, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0));
    while (nunits < 3) @(negedge clk);
    wr(7, 32'h0);
    repeat (20) @(negedge clk);
    u = 32'(nunits);
    chk(!bus_req && cur_cnt != 0 && u == 32'(10 - int'(cur_cnt)), "R8 master stop", u, 32'(10 - int'(cur_cnt)));
    repeat (10) @(negedge clk);
    chk(32'(nunits) == u, "R8 stays stopped", nunits, u);
    wr(7, 32'h1);
    wait_end(300);
    chk(nunits == 10 && tend_flag, "R8 resume", nunits, 10);
    wr(2, 32'd6);
    wr(3, cw(1, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0));
    while (nunits < 12) @(negedge clk);
    nmi_evt = 1'b1; @(negedge clk); nmi_evt = 1'b0;
    repeat (15) @(negedge clk);
    u = 32'(nunits);
    chk(nmi_flag && !bus_req && u < 16, "R8 nmi stop", u, 13);
    wr(7, 32'h3);
    repeat (10) @(negedge clk);
    chk(nmi_flag && 32'(nunits) == u, "R13 nmi keep", nunits, u);
    wr(7, 32'h1);
    wait_end(300);
    chk(nunits == 16 && !nmi_flag, "R8 nmi resume", nunits, 16);
    // channel enable off stops at once
    wr(2, 32'd4);
    wr(3, cw(0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0));
    repeat (20) @(negedge clk);
    chk(nunits == 16 && cur_cnt == 4, "R8 chan disabled", nunits, 16);
    dreq = 1'b0;

    // edge-sensed burst
    do_reset();
    lat = 3;
    wr(7, 32'h1);
    wr(0, 32'h0); wr(1, 32'h0); wr(2, 32'd4);
    wr(3, cw(1, 1, 0, 0, 1, 1, 0, 0, 1, 1, 0, 0));
    repeat (5) @(negedge clk);
    chk(nunits == 0, "R10 edge no request", nunits, 0);
    dreq = 1'b1; @(negedge clk); dreq = 1'b0;
    repeat (2) @(negedge clk);
    chk(bus_req, "R10 edge starts unit", bus_req, 1);
    dreq = 1'b1; @(negedge clk); dreq = 1'b0;
    repeat (40) @(negedge clk);
    chk(nunits == 2 && cur_cnt == 2, "R10 edge latched", nunits, 2);
    dreq = 1'b1;
    repeat (40) @(negedge clk);
    dreq = 1'b0;
    chk(nunits == 3, "R10 held high one unit", nunits, 3);

    // level-sensed burst and cycle steal
    do_reset();
    wr(7, 32'h1);
    wr(0, 32'h0); wr(1, 32'h0); wr(2, 32'd4);
    wr(3, cw(1, 1, 0, 0, 1, 1, 0, 0, 1, 0, 0, 0));
    repeat (20) @(negedge clk);
    chk(nunits == 0, "R10 level low idle", nunits, 0);
    dreq = 1'b1;
    wait_end(200);
    chk(nunits == 4, "R10 level burst runs", nunits, 4);
    dreq = 1'b0;
    do_reset();
    wr(7, 32'h1);
    wr(0, 32'h0); wr(1, 32'h0); wr(2, 32'd4);
    wr(3, cw(1, 1, 0, 0, 1, 1, 0, 0, 0, 1, 0, 0));
    dreq = 1'b1; @(negedge clk); dreq = 1'b0;
    repeat (30) @(negedge clk);
    chk(nunits == 1, "R10 steal is level", nunits, 1);

    // misaligned pointer
    do_reset();
    wr(7, 32'h1);
    wr(0, 32'h1002); wr(1, 32'h2000); wr(2, 32'd3);
    wr(3, cw(1, 1, 0, 0, 1, 1, 2, 1, 0, 0, 0, 0));
    repeat (10) @(negedge clk);
    chk(addr_err_flag && nunits == 0 && cur_cnt == 3, "R12 misaligned", nunits, 0);
    wr(0, 32'h1004);
    wr(7, 32'h1);
    wait_end(200);
    chk(!addr_err_flag && nunits == 3 && log_src[0] == 32'h1004, "R12 recover", log_src[0], 32'h1004);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule